// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between instruction fetch and the functional units of a wide-issue processor. It takes one fetch packet at a time over a valid/ready handshake. A fetch packet holds a fixed number of 32-bit instruction slots: eight slots, 256 bits in total. The dispatcher splits the packet into execute packets of variable length and issues one execute packet per clock. Bit 0 of each instruction is a chaining flag. A 1 joins the next slot to the current execute packet. A 0 closes the execute packet, so the next slot starts a new one on the following clock. The final slot always closes its execute packet, so an execute packet never runs past the end of a fetch packet.

The issue side presents three things: the instruction word for each lane, with lanes outside the current execute packet driven to zero; a lane mask that marks the slots being issued; and an issue strobe. While a stall input is high, every piece of state and every issue output holds its value. The block reads no part of an instruction except the chaining bit. It accepts the next fetch packet only when it holds no packet, or when the final execute packet of the held one is issued on that edge without a stall. Back-to-back fetch packets therefore keep the issue rate at one execute packet per clock.

Top module: `exec_pkt_dispatch`

## Requirements
- R1: After a synchronous reset, `iss_valid` is 0, `iss_mask` is 0, and `fp_ready` is 1 while `iss_stall` is low.
- R2: An execute packet starts at the first slot not yet issued. It takes every following slot up to and including the first slot whose bit 0 is 0. Slot k is bit k of `iss_mask` and bits [32k+31:32k] of the instruction words.
- R3: Slot 7 always closes its execute packet, even when its bit 0 is 1.
- R4: On each lane marked in `iss_mask`, `iss_words` carries that slot's instruction unchanged. Every unmarked lane carries zero. When `iss_valid` is 0, `iss_mask` is 0.
- R5: With fetch packets always offered and no stall, execute packets issue on consecutive clocks with no gap, including across fetch-packet boundaries.
- R6: `fp_ready` stays 0 while the held fetch packet still has execute packets to issue beyond the one computed on the coming edge.
- R7: `fp_ready` is 1 when no packet is held, or when the final execute packet of the held packet is issued on the coming edge without a stall. A packet is accepted on an edge where `fp_valid` and `fp_ready` are both 1.
- R8: While `iss_stall` is high, `fp_ready` is 0 and `iss_valid`, `iss_mask` and `iss_words` hold their values into the next cycle.
- R9: Every execute packet of every accepted fetch packet is issued exactly once, in slot order and fetch order. An issue counts as taken on an edge where `iss_valid` is 1 and `iss_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fp_valid | input | 1 | Fetch packet offered |
| fp_data | input | 256 | Fetch packet, slot k at bits [32k+31:32k] |
| fp_ready | output | 1 | Dispatcher takes the offered fetch packet on this edge |
| iss_stall | input | 1 | Freeze the dispatcher and its issue outputs |
| iss_valid | output | 1 | Issue strobe: an execute packet is presented |
| iss_mask | output | 8 | Lanes that belong to the presented execute packet |
| iss_words | output | 256 | Instruction word per lane, zero on unmarked lanes |

## Verification
The hardest case to reach is a stall that lands on the very edge where the final execute packet of a held packet would issue. A new fetch packet is waiting at that moment. Ready has to drop and the handover has to wait without losing or repeating an execute packet. The random phase gets there often because it draws a stall on about a quarter of the cycles and offers packets with random gaps, while the chaining bits are biased toward short runs. Directed packets cover the other extremes: one fully chained packet, one packet of eight single-slot execute packets, and one packet whose final slot carries a set chaining bit. These are run back to back to measure gap-free issue.

// File: rtl/epd_pkg.sv
package epd_pkg;
    localparam int unsigned SLOTS_DEF = 8;
    localparam int unsigned IW_DEF    = 32;
endpackage

// File: rtl/epd_span_find.sv
module epd_span_find #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned PTR_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] chain,
    input  logic [PTR_W-1:0] start,
    output logic [SLOTS-1:0] span_mask,
    output logic [PTR_W-1:0] span_end,
    output logic             span_final
);
    always_comb begin
        logic open;
        open      = 1'b1;
        span_mask = '0;
        span_end  = PTR_W'(SLOTS - 1);
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (i >= int'(start)) begin
                span_mask[i] = open;
                if (open && (!chain[i] || i == int'(SLOTS) - 1)) begin
                    span_end = PTR_W'(i);
                    open     = 1'b0;
                end
            end
        end
        span_final = (span_end == PTR_W'(SLOTS - 1));
    end
endmodule

// File: rtl/epd_lane_gate.sv
module epd_lane_gate #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IW    = 32
) (
    input  logic [SLOTS*IW-1:0] words_in,
    input  logic [SLOTS-1:0]    lane_en,
    output logic [SLOTS*IW-1:0] words_out
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        assign words_out[g*IW +: IW] = lane_en[g] ? words_in[g*IW +: IW] : '0;
    end
endmodule

// File: rtl/exec_pkt_dispatch.sv
module exec_pkt_dispatch
    import epd_pkg::*;
#(
    parameter int unsigned SLOTS = SLOTS_DEF,
    parameter int unsigned IW    = IW_DEF,
    localparam int unsigned PTR_W = $clog2(SLOTS),
    localparam int unsigned FP_W  = SLOTS * IW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fp_valid,
    input  logic [FP_W-1:0] fp_data,
    output logic            fp_ready,
    input  logic            iss_stall,
    output logic            iss_valid,
    output logic [SLOTS-1:0] iss_mask,
    output logic [FP_W-1:0] iss_words
);
    typedef struct packed {
        logic             held;
        logic [PTR_W-1:0] ptr;
        logic [FP_W-1:0]  pkt;
        logic             ivalid;
        logic [SLOTS-1:0] imask;
        logic [FP_W-1:0]  iwords;
    } st_t;

    st_t st_d, st_q;

    logic [SLOTS-1:0] chain_bits;
    logic [SLOTS-1:0] span_mask;
    logic [PTR_W-1:0] span_end;
    logic             span_final;
    logic [FP_W-1:0]  gated_words;

    for (genvar g = 0; g < SLOTS; g++) begin : g_chain
        assign chain_bits[g] = st_q.pkt[g*IW];
    end

    epd_span_find #(.SLOTS(SLOTS)) u_span (
        .chain      (chain_bits),
        .start      (st_q.ptr),
        .span_mask  (span_mask),
        .span_end   (span_end),
        .span_final (span_final)
    );

    epd_lane_gate #(.SLOTS(SLOTS), .IW(IW)) u_gate (
        .words_in  (st_q.pkt),
        .lane_en   (span_mask),
        .words_out (gated_words)
    );

    always_comb begin
        st_d     = st_q;
        fp_ready = !iss_stall && (!st_q.held || span_final);
        if (!iss_stall) begin
            st_d.ivalid = st_q.held;
            st_d.imask  = st_q.held ? span_mask   : '0;
            st_d.iwords = st_q.held ? gated_words : '0;
            if (st_q.held) begin
                if (span_final) begin
                    st_d.held = 1'b0;
                    st_d.ptr  = '0;
                end else begin
                    st_d.ptr = span_end + PTR_W'(1);
                end
            end
            if (fp_valid && fp_ready) begin
                st_d.held = 1'b1;
                st_d.pkt  = fp_data;
                st_d.ptr  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iss_valid = st_q.ivalid;
    assign iss_mask  = st_q.imask;
    assign iss_words = st_q.iwords;
endmodule

// File: rtl/epd_checker.sv
module epd_checker #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IW    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                fp_ready,
    input logic                iss_stall,
    input logic                iss_valid,
    input logic [SLOTS-1:0]    iss_mask,
    input logic [SLOTS*IW-1:0] iss_words
);
    logic [SLOTS-1:0] low_bit;
    logic             lanes_clear;

    always_comb begin
        low_bit     = iss_mask & (~iss_mask + SLOTS'(1));
        lanes_clear = 1'b1;
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (!iss_mask[i] && iss_words[i*IW +: IW] != '0) lanes_clear = 1'b0;
        end
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        iss_stall |=> ($stable(iss_valid) && $stable(iss_mask) && $stable(iss_words))); // R8
    AST_NO_READY_IN_STALL: assert property (@(posedge clk) disable iff (rst)
        iss_stall |-> !fp_ready); // R8
    AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_mask != '0 && ((iss_mask + low_bit) & iss_mask) == '0)); // R2
    AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> iss_mask == '0); // R4
    AST_UNUSED_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        lanes_clear); // R4
endmodule

bind exec_pkt_dispatch epd_checker #(.SLOTS(SLOTS), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fp_ready  (fp_ready),
    .iss_stall (iss_stall),
    .iss_valid (iss_valid),
    .iss_mask  (iss_mask),
    .iss_words (iss_words)
);

// File: tb/sim_exec_pkt_dispatch.sv
module sim_exec_pkt_dispatch;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fp_valid = 1'b0;
    logic [255:0] fp_data = '0;
    logic         fp_ready;
    logic         iss_stall = 1'b0;
    logic         iss_valid;
    logic [7:0]   iss_mask;
    logic [255:0] iss_words;

    always #2ns clk = ~clk;

    exec_pkt_dispatch u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [255:0] src [0:255];
    int src_wr = 0, src_rd = 0;
    logic [7:0]   q_mask  [0:2047];
    logic [255:0] q_words [0:2047];
    bit           q_last  [0:2047];
    int q_wr = 0, q_rd = 0;
    bit acc_pending = 0;
    bit prev_stall = 0;
    logic         prev_valid;
    logic [7:0]   prev_mask;
    logic [255:0] prev_words;
    int run = 0, max_run = 0;

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_eps(input logic [255:0] p);
        int s = 0;
        while (s < 8) begin
            logic [7:0]   m = '0;
            logic [255:0] w = '0;
            int e = 7;
            for (int k = s; k < 8; k++) begin
                m[k] = 1'b1;
                w[k*32 +: 32] = p[k*32 +: 32];
                if (p[k*32] == 1'b0 || k == 7) begin
                    e = k;
                    break;
                end
            end
            q_mask[q_wr] = m; q_words[q_wr] = w; q_last[q_wr] = (e == 7);
            q_wr++;
            s = e + 1;
        end
    endtask

    function automatic logic [255:0] rand_pkt();
        logic [255:0] p;
        for (int k = 0; k < 8; k++) begin
            p[k*32 +: 32] = $urandom;
            p[k*32] = (($urandom % 100) < 40);
        end
        return p;
    endfunction

    task automatic step(input int stall_p, input int valid_p);
        int nxt;
        bit exp_ready;
        @(negedge clk);
        if (acc_pending) begin fp_valid = 1'b0; acc_pending = 0; end
        iss_stall = (($urandom % 100) < stall_p);
        if (!fp_valid && src_rd < src_wr && (($urandom % 100) < valid_p)) begin
            fp_valid = 1'b1;
            fp_data  = src[src_rd];
        end
        #1;
        if (prev_stall) begin
            check(iss_valid == prev_valid && iss_mask == prev_mask && iss_words == prev_words,
                  "R8 outputs frozen", {iss_mask, 7'd0, iss_valid}, {prev_mask, 7'd0, prev_valid});
        end
        nxt = q_rd + (iss_valid ? 1 : 0);
        exp_ready = !iss_stall && (nxt >= q_wr || q_last[nxt]);
        check(fp_ready == exp_ready, iss_stall ? "R8 ready low in stall" :
              (exp_ready ? "R7 ready" : "R6 ready held low"), fp_ready, exp_ready);
        if (!iss_valid) check(iss_mask == 8'h00, "R4 idle mask", iss_mask, 0);
        if (iss_valid && !iss_stall) begin
            if (q_rd >= q_wr) begin
                check(0, "R9 unexpected issue", iss_mask, 0);
            end else begin
                check(iss_mask == q_mask[q_rd], q_mask[q_rd][7] ? "R3 mask" : "R2 mask",
                      iss_mask, q_mask[q_rd]);
                check(iss_words == q_words[q_rd], "R4 words", iss_words, q_words[q_rd]);
                q_rd++;
            end
        end
        if (fp_valid && fp_ready) begin
            push_eps(fp_data);
            src_rd++;
            acc_pending = 1;
        end
        run = iss_valid ? run + 1 : 0;
        if (run > max_run) max_run = run;
        prev_stall = iss_stall; prev_valid = iss_valid; prev_mask = iss_mask; prev_words = iss_words;
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(iss_valid == 1'b0, "R1 strobe low", iss_valid, 0);
        check(iss_mask == 8'h00, "R1 mask clear", iss_mask, 0);
        check(fp_ready == 1'b1, "R1 ready", fp_ready, 1);

        // directed: fully chained, all single-slot, slot 7 chain bit set (R3)
        for (int k = 0; k < 8; k++) begin
            src[0][k*32 +: 32] = 32'h1000_0001 + k*16;
            src[1][k*32 +: 32] = 32'h2000_0000 + k*16;
            src[2][k*32 +: 32] = (k >= 5) ? 32'h3000_0001 + k*16 : 32'h3000_0000 + k*16;
        end
        src_wr = 3;
        max_run = 0;
        for (int c = 0; c < 40; c++) step(0, 100);
        check(max_run == 15, "R5 gap-free issue run", max_run, 15);
        check(q_rd == 15 && q_wr == 15, "R9 directed count", q_rd, 15);

        for (int n = 0; n < 200; n++) begin
            src[src_wr] = rand_pkt();
            src_wr++;
        end
        for (int c = 0; c < 6000 && (src_rd < src_wr || q_rd < q_wr); c++) step(25, 60);
        for (int c = 0; c < 20; c++) step(0, 0);
        check(src_rd == src_wr, "R9 all packets accepted", src_rd, src_wr);
        check(q_rd == q_wr, "R9 all execute packets issued", q_rd, q_wr);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule